// File: doc/BRIEF.md
# Strobe-Addressed Bit Memory with Row Latch

This core models a one-bit-wide memory arranged as a square grid of cells. The grid has 2^ADDR_W rows and 2^ADDR_W columns, which gives a 256 x 256 grid (64K bits) at the default setting. A full address is split into a row half and a column half. Both halves are presented on the same narrow address pins, one after the other, and each is qualified by its own active-low strobe. All strobes are sampled on the system clock, so every strobe edge is seen as a clock-synchronous event.

When the row strobe falls, the whole selected row is moved into a row-wide latch and that row in the grid is left all zeros. The move is destructive. Each fall of the column strobe then reads or writes one bit of the latch. Several column strobes may follow a single row strobe, and all of them act on the same row. When the row strobe rises, the latch is copied back into the grid. A row that never gets that copy-back, for example because reset arrives while it is open, comes back as zeros. A column strobe that arrives with no row open is dropped and flagged.

Top module: `dram_core`

## Requirements
- R1: While rst_n is low and after its release, dout and err are 0 and no row is open.
- R2: The full bit address is {row, col}. The row half occupies the upper ADDR_W bits and is taken from addr at the clock edge where ras_n is first seen low. The column half is taken from addr at the clock edge where cas_n is first seen low.
- R3: Opening a row loads all 2^ADDR_W bits of that row into the row latch and clears the row in the grid. If the latch is then lost through reset, reopening the row reads all zeros.
- R4: If rw=1 when cas_n falls, dout shows the selected latch bit from the clock edge where the fall is seen. It holds that value while cas_n stays low and returns to 0 at the first edge where cas_n is seen high.
- R5: If rw=0 when cas_n falls, the selected latch bit takes din, and dout stays 0.
- R6: At the edge where ras_n is seen rising with a row open, the whole latch is written back into the grid row. A new row may be opened at the very next edge.
- R7: A cas_n fall with no row open changes no stored bit and leaves dout at 0. err is high for exactly one cycle after that edge.
- R8: Several cas_n strobes inside one row access reach different columns of the same row. A bit written earlier in the row is returned by a later read in the same row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| addr | input | ADDR_W | Multiplexed address: row half at row strobe, column half at column strobe |
| ras_n | input | 1 | Active-low row strobe; fall opens a row, rise writes it back |
| cas_n | input | 1 | Active-low column strobe; fall performs one bit access |
| rw | input | 1 | Access kind at column strobe: 1 read, 0 write |
| din | input | 1 | Write data bit |
| dout | output | 1 | Read data bit, 0 when no read is being shown |
| err | output | 1 | One-cycle pulse for a column strobe with no open row |

## Verification
The bench runs at ADDR_W=3 and sweeps every bit of the 8 x 8 grid with two different patterns. One pattern is written a whole row at a time using several column strobes. The other is written one bit per row opening. After each write pass the whole grid is read back, so a design that dropped the write-back, wrote back only one bit, or swapped the row and column halves would return a pattern that does not match. The bench drops reset while a row is open and then reopens that row, expecting zeros. A design that did not clear the row on activation would return the old data instead. It issues a column strobe with no row open and confirms that err pulses for one cycle and that no stored bit changed. It also holds each read strobe low for an extra cycle and reopens a row one clock after closing the previous one, which catches output that does not hold and write-back that races the next activation.

// File: rtl/dram_core_pkg.sv
package dram_core_pkg;

  // Synchronous view of one active-low strobe.
  typedef struct packed {
    logic fall;     // seen low now, was high at the previous edge
    logic rise;     // seen high now, was low at the previous edge
    logic level_q;  // level registered at the previous edge
  } strobe_ev_t;

endpackage

// File: rtl/strobe_edges.sv
module strobe_edges
  import dram_core_pkg::*;
#(
  parameter int N = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N-1:0]           strobe_n,
  output strobe_ev_t [N-1:0]     ev
);

  logic [N-1:0] lvl_q;

  for (genvar g = 0; g < N; g++) begin : g_strobe
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q[g] <= 1'b1;
      else        lvl_q[g] <= strobe_n[g];
    end

    assign ev[g].fall    = lvl_q[g] & ~strobe_n[g];
    assign ev[g].rise    = ~lvl_q[g] & strobe_n[g];
    assign ev[g].level_q = lvl_q[g];
  end

endmodule

// File: rtl/cell_array.sv
module cell_array #(
  parameter int ADDR_W = 8,
  localparam int ROWS  = 1 << ADDR_W,
  localparam int COLS  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              act,
  input  logic [ADDR_W-1:0] act_row,
  input  logic              restore,
  input  logic [ADDR_W-1:0] wb_row,
  input  logic [COLS-1:0]   wb_data,
  output logic [COLS-1:0]   rd_data
);

  logic [COLS-1:0] mem [ROWS];

  assign rd_data = mem[act_row];

  // One write port: activation clears the row, restore writes the latch back.
  always_ff @(posedge clk) begin
    if (act)          mem[act_row] <= '0;
    else if (restore) mem[wb_row]  <= wb_data;
  end

endmodule

// File: rtl/row_buffer.sv
module row_buffer #(
  parameter int ADDR_W = 8,
  localparam int COLS  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act,
  input  logic              close,
  input  logic              col_fall,
  input  logic              cas_high,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rw,
  input  logic              din,
  input  logic [COLS-1:0]   fill_data,
  output logic [COLS-1:0]   buf_q,
  output logic [ADDR_W-1:0] row_q,
  output logic              open_q,
  output logic              dout,
  output logic              err
);

  logic [COLS-1:0]   buf_d;
  logic [ADDR_W-1:0] row_d;
  logic              open_d, dout_d, err_d;

  always_comb begin
    buf_d  = buf_q;
    row_d  = row_q;
    open_d = open_q;
    dout_d = dout;
    err_d  = 1'b0;

    if (act) begin
      buf_d  = fill_data;
      row_d  = addr;
      open_d = 1'b1;
    end else if (close) begin
      open_d = 1'b0;
    end

    if (col_fall) begin
      if (open_q) begin
        if (rw) begin
          dout_d = buf_q[addr];
        end else begin
          buf_d[addr] = din;
          dout_d      = 1'b0;
        end
      end else begin
        err_d = 1'b1;
      end
    end else if (cas_high) begin
      dout_d = 1'b0;
    end
  end

  // Data path registers: no reset needed.
  always_ff @(posedge clk) begin
    buf_q <= buf_d;
    row_q <= row_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      dout   <= 1'b0;
      err    <= 1'b0;
    end else begin
      open_q <= open_d;
      dout   <= dout_d;
      err    <= err_d;
    end
  end

endmodule

// File: rtl/dram_core.sv
module dram_core
  import dram_core_pkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int COLS  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              rw,
  input  logic              din,
  output logic              dout,
  output logic              err
);

  localparam int RAS_IDX = 0;
  localparam int CAS_IDX = 1;

  strobe_ev_t [1:0]  ev;
  logic              ras_fall, ras_rise, cas_fall, cas_q;
  logic              open_q, restore;
  logic [COLS-1:0]   buf_q, rd_data;
  logic [ADDR_W-1:0] row_q;

  strobe_edges #(.N(2)) u_edges (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_n ({cas_n, ras_n}),
    .ev       (ev)
  );

  assign ras_fall = ev[RAS_IDX].fall;
  assign ras_rise = ev[RAS_IDX].rise;
  assign cas_fall = ev[CAS_IDX].fall;
  assign cas_q    = ev[CAS_IDX].level_q;
  assign restore  = ras_rise & open_q;

  cell_array #(.ADDR_W(ADDR_W)) u_array (
    .clk     (clk),
    .act     (ras_fall),
    .act_row (addr),
    .restore (restore),
    .wb_row  (row_q),
    .wb_data (buf_q),
    .rd_data (rd_data)
  );

  row_buffer #(.ADDR_W(ADDR_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .act       (ras_fall),
    .close     (restore),
    .col_fall  (cas_fall),
    .cas_high  (cas_n),
    .addr      (addr),
    .rw        (rw),
    .din       (din),
    .fill_data (rd_data),
    .buf_q     (buf_q),
    .row_q     (row_q),
    .open_q    (open_q),
    .dout      (dout),
    .err       (err)
  );

endmodule

// File: rtl/dram_core_chk.sv
module dram_core_chk (
  input logic clk,
  input logic rst_n,
  input logic cas_n,
  input logic rw,
  input logic dout,
  input logic err,
  input logic row_open,
  input logic ras_fall,
  input logic ras_rise,
  input logic cas_fall,
  input logic cas_q
);

  p_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ras_fall |=> row_open);

  p_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ras_rise |=> !row_open);

  p_dout_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cas_n |=> !dout);

  p_dout_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_q && !cas_n) |=> $stable(dout));

  p_write_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_fall && row_open && !rw) |=> !dout);

  p_err_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(cas_fall && !row_open));

  p_err_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_fall && !row_open) |=> err);

endmodule

bind dram_core dram_core_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cas_n    (cas_n),
  .rw       (rw),
  .dout     (dout),
  .err      (err),
  .row_open (open_q),
  .ras_fall (ras_fall),
  .ras_rise (ras_rise),
  .cas_fall (cas_fall),
  .cas_q    (cas_q)
);

// File: tb/sim_dram_core.sv
module sim_dram_core;

  localparam int AW = 3;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          ras_n, cas_n, rw, din;
  logic          dout, err;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;
  bit  model [N][N];

  always #4 clk = ~clk;

  dram_core #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ras_n(ras_n), .cas_n(cas_n),
    .rw(rw), .din(din), .dout(dout), .err(err)
  );

  function automatic bit pat(int r, int c, int k);
    return bit'((((r * 5 + c * 3 + k) >> 1) ^ c ^ k) & 1);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic open_row(int r);
    addr = AW'(r); ras_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic close_row();
    ras_n = 1'b1;
    @(negedge clk);
  endtask

  // R4: read shown one edge after the fall, held, then cleared.
  task automatic rd_bit(int c, bit exp, string req);
    addr = AW'(c); rw = 1'b1; cas_n = 1'b0;
    @(negedge clk);
    chk(dout == exp, req, dout, exp);
    @(negedge clk);
    chk(dout == exp, "R4 hold", dout, exp);
    cas_n = 1'b1;
    @(negedge clk);
    chk(dout == 1'b0, "R4 clear", dout, 0);
  endtask

  // R5: write sets the latch bit and keeps dout low.
  task automatic wr_bit(int c, bit d);
    addr = AW'(c); rw = 1'b0; din = d; cas_n = 1'b0;
    @(negedge clk);
    chk(dout == 1'b0, "R5 dout low on write", dout, 0);
    cas_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic read_all(string req);
    for (int r = 0; r < N; r++) begin
      open_row(r);
      for (int c = 0; c < N; c++) rd_bit(c, model[r][c], req);
      close_row();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; addr = '0; ras_n = 1'b1; cas_n = 1'b1; rw = 1'b1; din = 1'b0;
    repeat (3) @(negedge clk);
    chk(dout == 1'b0, "R1 dout in reset", dout, 0);
    chk(err == 1'b0, "R1 err in reset", err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dout == 1'b0 && err == 1'b0, "R1 after release", {dout, err}, 0);

    // R8: page-mode write of pattern 0, one open per row.
    for (int r = 0; r < N; r++) begin
      open_row(r);
      for (int c = 0; c < N; c++) begin
        wr_bit(c, pat(r, c, 0));
        model[r][c] = pat(r, c, 0);
      end
      close_row();
    end
    read_all("R2/R6 page pattern");

    // R6: one bit per row opening; write-back must keep the others.
    for (int r = 0; r < N; r++) begin
      for (int c = 0; c < N; c++) begin
        open_row(r);
        wr_bit(c, pat(r, c, 1));
        model[r][c] = pat(r, c, 1);
        close_row();
      end
    end
    read_all("R6 single-bit pattern");

    // R8: write then read back within the same row opening.
    open_row(2);
    wr_bit(6, ~model[2][6]);
    model[2][6] = ~model[2][6];
    rd_bit(6, model[2][6], "R8 same-row readback");
    rd_bit(1, model[2][1], "R8 other column");
    close_row();

    // R7: column strobe with no row open.
    addr = AW'(3); rw = 1'b0; din = ~model[3][3]; cas_n = 1'b0;
    @(negedge clk);
    chk(err == 1'b1, "R7 err raised", err, 1);
    chk(dout == 1'b0, "R7 dout low", dout, 0);
    @(negedge clk);
    chk(err == 1'b0, "R7 err one cycle", err, 0);
    cas_n = 1'b1;
    @(negedge clk);
    for (int r = 0; r < N; r++) begin
      open_row(r);
      rd_bit(3, model[r][3], "R7 no bit changed");
      close_row();
    end

    // R3: lose the latch via reset; the row must come back cleared.
    open_row(5);
    rst_n = 1'b0; ras_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dout == 1'b0 && err == 1'b0, "R1 mid-run reset", {dout, err}, 0);
    for (int c = 0; c < N; c++) model[5][c] = 1'b0;
    open_row(5);
    for (int c = 0; c < N; c++) rd_bit(c, 1'b0, "R3 row cleared");
    close_row();
    read_all("R3 other rows intact");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule